// File: doc/BRIEF.md
# Fixed Off-Time Bridge Current Chopper

This block regulates the current in one motor winding driven by a full bridge of four switches. It closes a diagonal source/sink pair so current builds through the winding. When an external comparator reports that the sensed current has reached its programmed level, the block stops driving and lets the current decay for a fixed number of clock cycles. It then drives again, and the cycle repeats for as long as it is enabled. The two half-bridges are called leg A and leg B. Each leg has a high-side (source) enable and a low-side (sink) enable.

The decay style comes from the step sequencer. Slow decay opens only the source switch, so the winding recirculates through both low sides. Mixed decay starts with a fast portion where every switch is open, then changes to slow recirculation for the rest of the off-time. A low-current select forces a fixed off-time that equals 30 µs at the design clock, and it also forces mixed decay on every cycle. A blanking window at the start of each drive masks the comparator, which rejects switching spikes and sets a minimum on-time. A break-before-make cycle separates any switch turning off from the opposite switch in the same leg turning on.

Top module: `offtime_chopper`

## Requirements
- R1: While `rst_n` is low, all four switch enables are 0 and `phase` is 2'b00 (idle). The asynchronous assertion of reset clears them at once.
- R2: The drive pair follows `polarity`. With 0, the pair is `src_a` and `snk_b`. With 1, the pair is `src_b` and `snk_a`. Each on phase starts with one cycle in which only the sink of that pair is enabled, and the full pair is enabled from the next cycle.
- R3: For BLANK_CYC cycles after the pair closes (default 4), `trip` is ignored. If `trip` is held high, the pair stays closed for exactly BLANK_CYC+1 cycles.
- R4: After blanking, a high `trip` sampled at a clock edge ends the drive. From that edge on, `phase` shows decay (2'b10 or 2'b11).
- R5: In slow decay (`decay_mixed`=0), the first off-time cycle keeps only the sink of the drive pair enabled. After that, `snk_a` and `snk_b` are both enabled with both sources off, and `phase` is 2'b11 for the whole off-time.
- R6: In mixed decay (`decay_mixed`=1), all four enables are 0 and `phase` is 2'b10 for F = max(1, N>>FAST_SH) cycles (default FAST_SH=2). For the remaining N−F cycles, both sinks are enabled and `phase` is 2'b11.
- R7: The off-time lasts exactly N cycles, where N = `off_cycles` clamped to a minimum of 2. The on phase then restarts as in R2. N and F are captured when the trip is taken.
- R8: With `low_cur`=1, N = CLK_MHZ·LOW_US (3000 at defaults) whatever `off_cycles` is, and the decay is mixed whatever `decay_mixed` is.
- R9: The source and sink enables of the same leg are never both 1. A sink or source enable is never 1 in the cycle right after the opposite enable of its leg was 1.
- R10: `polarity` is captured only when an on phase starts. A change during drive or decay has no effect until the next on phase.
- R11: A low `enable` at a clock edge clears all four enables and sets `phase` to 2'b00 from that edge on. A later high `enable` starts a fresh on phase as in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Run the chopper; low forces every switch open |
| trip | input | 1 | Comparator output: winding current reached its level |
| polarity | input | 1 | Winding current direction (0: A→B, 1: B→A) |
| decay_mixed | input | 1 | 1 selects mixed decay, 0 slow decay |
| low_cur | input | 1 | Select fixed 30 µs off-time with forced mixed decay |
| off_cycles | input | CNT_W | Off-time length in clock cycles (minimum 2) |
| src_a | output | 1 | Leg A high-side enable |
| snk_a | output | 1 | Leg A low-side enable |
| src_b | output | 1 | Leg B high-side enable |
| snk_b | output | 1 | Leg B low-side enable |
| phase | output | 2 | 00 idle, 01 on, 10 fast decay, 11 slow decay |

## Verification
Every output is a decode of registered state, so each result is due one clock edge after the input that causes it. This covers the switch to decay after a sampled trip, the idle state after a low enable, and the sink-only first cycle after an enable. Blanking ends BLANK_CYC+1 edges after the pair closes, and decay lasts exactly N edges. The bench changes inputs and samples outputs only on falling edges. It therefore sees the values set by the preceding rising edge, and it measures phase lengths by counting consecutive falling-edge samples. A per-cycle monitor compares each sample with the previous one to catch an overlap or a missing break-before-make cycle.

// File: rtl/chop_pkg.sv
package chop_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_GAP_ON, ST_BLANK, ST_DRIVE, ST_GAP_OFF, ST_FAST, ST_SLOW
  } chop_st_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00, PH_ON = 2'b01, PH_FAST = 2'b10, PH_SLOW = 2'b11
  } chop_ph_t;

  typedef struct packed {
    logic src_a;
    logic snk_a;
    logic src_b;
    logic snk_b;
  } gate_t;
endpackage

// File: rtl/chop_rst_sync.sv
module chop_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/chop_len_sel.sv
module chop_len_sel #(
  parameter int CNT_W   = 16,
  parameter int FAST_SH = 2,
  parameter int LOW_CYC = 3000
) (
  input  logic [CNT_W-1:0] off_cycles,
  input  logic             low_cur,
  input  logic             decay_mixed,
  output logic [CNT_W-1:0] len_o,
  output logic [CNT_W-1:0] fast_o,
  output logic             mixed_o
);
  localparam logic [CNT_W-1:0] LOW_N = CNT_W'(LOW_CYC);
  localparam logic [CNT_W-1:0] MIN_N = CNT_W'(2);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic [CNT_W-1:0] raw_len;
  logic [CNT_W-1:0] raw_fast;

  always_comb begin
    raw_len  = low_cur ? LOW_N : off_cycles;
    len_o    = (raw_len < MIN_N) ? MIN_N : raw_len;
    raw_fast = len_o >> FAST_SH;
    fast_o   = (raw_fast == '0) ? ONE : raw_fast;
    mixed_o  = decay_mixed | low_cur;
  end
endmodule

// File: rtl/chop_seq.sv
module chop_seq
  import chop_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int BLANK_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             trip,
  input  logic             polarity,
  input  logic             mixed,
  input  logic [CNT_W-1:0] len_i,
  input  logic [CNT_W-1:0] fast_i,
  output chop_st_t         state_o,
  output logic             pol_o,
  output chop_ph_t         phase_o
);
  localparam logic [CNT_W-1:0] BLANK_LAST = CNT_W'(BLANK_CYC - 1);

  chop_st_t         state_q, state_d;
  logic [CNT_W-1:0] tmr_q, tmr_d;
  logic [CNT_W-1:0] len_q, len_d;
  logic [CNT_W-1:0] fast_q, fast_d;
  logic             pol_q, pol_d;

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q;
    len_d   = len_q;
    fast_d  = fast_q;
    pol_d   = pol_q;
    if (!enable) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: begin
          state_d = ST_GAP_ON;
          pol_d   = polarity;
        end
        ST_GAP_ON: begin
          state_d = ST_BLANK;
          tmr_d   = '0;
        end
        ST_BLANK: begin
          if (tmr_q == BLANK_LAST) state_d = ST_DRIVE;
          else                     tmr_d   = tmr_q + 1'b1;
        end
        ST_DRIVE: begin
          if (trip) begin
            state_d = mixed ? ST_FAST : ST_GAP_OFF;
            tmr_d   = '0;
            len_d   = len_i;
            fast_d  = fast_i;
          end
        end
        ST_GAP_OFF, ST_FAST, ST_SLOW: begin
          if (tmr_q == len_q - 1'b1) begin
            state_d = ST_GAP_ON;
            pol_d   = polarity;
          end else begin
            tmr_d = tmr_q + 1'b1;
            if (state_q == ST_GAP_OFF ||
                (state_q == ST_FAST && tmr_q == fast_q - 1'b1))
              state_d = ST_SLOW;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
      len_q   <= '0;
      fast_q  <= '0;
      pol_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
      len_q   <= len_d;
      fast_q  <= fast_d;
      pol_q   <= pol_d;
    end
  end

  always_comb begin
    case (state_q)
      ST_GAP_ON, ST_BLANK, ST_DRIVE: phase_o = PH_ON;
      ST_FAST:                       phase_o = PH_FAST;
      ST_GAP_OFF, ST_SLOW:           phase_o = PH_SLOW;
      default:                       phase_o = PH_IDLE;
    endcase
  end

  assign state_o = state_q;
  assign pol_o   = pol_q;
endmodule

// File: rtl/chop_gate_dec.sv
module chop_gate_dec
  import chop_pkg::*;
(
  input  chop_st_t state,
  input  logic     pol,
  output gate_t    gates
);
  always_comb begin
    gates = '0;
    case (state)
      ST_GAP_ON, ST_GAP_OFF: begin
        if (pol) gates.snk_a = 1'b1;
        else     gates.snk_b = 1'b1;
      end
      ST_BLANK, ST_DRIVE: begin
        if (pol) begin
          gates.src_b = 1'b1;
          gates.snk_a = 1'b1;
        end else begin
          gates.src_a = 1'b1;
          gates.snk_b = 1'b1;
        end
      end
      ST_SLOW: begin
        gates.snk_a = 1'b1;
        gates.snk_b = 1'b1;
      end
      default: gates = '0;
    endcase
  end
endmodule

// File: rtl/offtime_chopper.sv
module offtime_chopper
  import chop_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int BLANK_CYC = 4,
  parameter int FAST_SH   = 2,
  parameter int CLK_MHZ   = 100,
  parameter int LOW_US    = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             trip,
  input  logic             polarity,
  input  logic             decay_mixed,
  input  logic             low_cur,
  input  logic [CNT_W-1:0] off_cycles,
  output logic             src_a,
  output logic             snk_a,
  output logic             src_b,
  output logic             snk_b,
  output logic [1:0]       phase
);
  localparam int LOW_CYC = CLK_MHZ * LOW_US;

  logic             rst_n_sync;
  logic [CNT_W-1:0] sel_len;
  logic [CNT_W-1:0] sel_fast;
  logic             sel_mixed;
  chop_st_t         seq_st;
  logic             seq_pol;
  chop_ph_t         seq_ph;
  gate_t            gate_v;

  chop_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_sync)
  );

  chop_len_sel #(.CNT_W(CNT_W), .FAST_SH(FAST_SH), .LOW_CYC(LOW_CYC)) u_len (
    .off_cycles  (off_cycles),
    .low_cur     (low_cur),
    .decay_mixed (decay_mixed),
    .len_o       (sel_len),
    .fast_o      (sel_fast),
    .mixed_o     (sel_mixed)
  );

  chop_seq #(.CNT_W(CNT_W), .BLANK_CYC(BLANK_CYC)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .enable   (enable),
    .trip     (trip),
    .polarity (polarity),
    .mixed    (sel_mixed),
    .len_i    (sel_len),
    .fast_i   (sel_fast),
    .state_o  (seq_st),
    .pol_o    (seq_pol),
    .phase_o  (seq_ph)
  );

  chop_gate_dec u_dec (
    .state (seq_st),
    .pol   (seq_pol),
    .gates (gate_v)
  );

  assign src_a = gate_v.src_a;
  assign snk_a = gate_v.snk_a;
  assign src_b = gate_v.src_b;
  assign snk_b = gate_v.snk_b;
  assign phase = seq_ph;
endmodule

// File: rtl/chop_chk.sv
module chop_chk
  import chop_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       trip,
  input chop_st_t   st,
  input logic       src_a,
  input logic       snk_a,
  input logic       src_b,
  input logic       snk_b,
  input logic [1:0] phase
);
  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(src_a && snk_a) && !(src_b && snk_b));

  assert_break_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(snk_a) |-> !src_a) and ($past(src_a) |-> !snk_a));

  assert_break_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(snk_b) |-> !src_b) and ($past(src_b) |-> !snk_b));

  assert_disable_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!src_a && !snk_a && !src_b && !snk_b && phase == 2'b00));

  assert_trip_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DRIVE && trip && enable) |=> phase[1]);

  assert_blank_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BLANK && enable) |=> (phase == 2'b01 && (src_a || src_b)));

  assert_fast_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'b10) |-> (!src_a && !snk_a && !src_b && !snk_b));
endmodule

bind offtime_chopper chop_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .enable (enable),
  .trip   (trip),
  .st     (seq_st),
  .src_a  (src_a),
  .snk_a  (snk_a),
  .src_b  (src_b),
  .snk_b  (snk_b),
  .phase  (phase)
);

// File: tb/offtime_chopper_test.sv
module offtime_chopper_test;
  localparam int BL = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        trip = 1'b0;
  logic        polarity = 1'b0;
  logic        decay_mixed = 1'b0;
  logic        low_cur = 1'b0;
  logic [15:0] off_cycles = 16'd10;
  logic        src_a, snk_a, src_b, snk_b;
  logic [1:0]  phase;
  wire  [3:0]  g = {src_a, snk_a, src_b, snk_b};

  int nchk = 0;
  int nfail = 0;
  int viol = 0;
  logic [3:0] g_prev = 4'b0000;

  offtime_chopper uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .trip(trip),
    .polarity(polarity), .decay_mixed(decay_mixed), .low_cur(low_cur),
    .off_cycles(off_cycles), .src_a(src_a), .snk_a(snk_a),
    .src_b(src_b), .snk_b(snk_b), .phase(phase)
  );

  always #4 clk = ~clk;

  // R9 monitor: overlap and break-before-make, per falling-edge sample
  always @(negedge clk) begin
    if (rst_n) begin
      if ((g[3] && g[2]) || (g[1] && g[0])) viol++;
      if ((g_prev[3] && g[2]) || (g_prev[2] && g[3]) ||
          (g_prev[1] && g[0]) || (g_prev[0] && g[1])) viol++;
    end
    g_prev = g;
  end

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_phase(input logic [1:0] p, output int n);
    n = 0;
    while (phase == p && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic run_pair(output int n);
    n = 0;
    while ((src_a || src_b) && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic go_idle();
    enable = 1'b0;
    trip = 1'b0;
    low_cur = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    enable = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 gates in reset", g, 0);
    check("R1 phase in reset", phase, 0);
    enable = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle after release", {phase, g}, 0);
  endtask

  task automatic t_slow();
    int n;
    polarity = 1'b0; decay_mixed = 1'b0; off_cycles = 16'd20;
    trip = 1'b1; enable = 1'b1;
    @(negedge clk);
    check("R2 sink-first p0", g, 4'b0001);
    check("R2 phase on", phase, 1);
    @(negedge clk);
    check("R2 pair p0", g, 4'b1001);
    run_pair(n);
    check("R3 blank with trip held", n, BL + 1);
    check("R5 first off cycle", g, 4'b0001);
    check("R5 phase slow", phase, 3);
    @(negedge clk);
    check("R5 both sinks", g, 4'b0101);
    run_phase(2'b11, n);
    check("R7 off length 20", n + 1, 20);
    check("R7 back on", {phase, g}, {2'b01, 4'b0001});
    go_idle();
  endtask

  task automatic t_trip_edge();
    polarity = 1'b0; decay_mixed = 1'b0; off_cycles = 16'd8;
    trip = 1'b0; enable = 1'b1;
    repeat (12) @(negedge clk);
    check("R4 stays driving without trip", {phase, g}, {2'b01, 4'b1001});
    trip = 1'b1;
    @(negedge clk);
    check("R4 decay one edge after trip", phase, 3);
    go_idle();
  endtask

  task automatic t_mixed();
    int n;
    polarity = 1'b1; decay_mixed = 1'b1; off_cycles = 16'd40;
    trip = 1'b1; enable = 1'b1;
    @(negedge clk);
    check("R2 sink-first p1", g, 4'b0100);
    @(negedge clk);
    check("R2 pair p1", g, 4'b0110);
    run_pair(n);
    check("R3 blank p1", n, BL + 1);
    check("R6 fast all open", {phase, g}, {2'b10, 4'b0000});
    run_phase(2'b10, n);
    check("R6 fast length", n, 10);
    check("R6 slow part sinks", {phase, g}, {2'b11, 4'b0101});
    run_phase(2'b11, n);
    check("R6 slow length", n, 30);
    go_idle();
  endtask

  task automatic t_lowcur();
    int n;
    polarity = 1'b0; decay_mixed = 1'b0; off_cycles = 16'd10;
    low_cur = 1'b1; trip = 1'b1; enable = 1'b1;
    @(negedge clk);
    @(negedge clk);
    run_pair(n);
    check("R8 forced mixed", phase, 2);
    run_phase(2'b10, n);
    check("R8 fast part", n, 750);
    run_phase(2'b11, n);
    check("R8 slow part", n, 2250);
    go_idle();
  endtask

  task automatic t_minoff();
    int n;
    polarity = 1'b0; decay_mixed = 1'b0; off_cycles = 16'd0;
    trip = 1'b1; enable = 1'b1;
    @(negedge clk);
    @(negedge clk);
    run_pair(n);
    run_phase(2'b11, n);
    check("R7 clamp to 2", n, 2);
    go_idle();
  endtask

  task automatic t_polarity();
    int n;
    polarity = 1'b0; decay_mixed = 1'b0; off_cycles = 16'd6;
    trip = 1'b0; enable = 1'b1;
    repeat (8) @(negedge clk);
    polarity = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 drive keeps old polarity", g, 4'b1001);
    trip = 1'b1;
    @(negedge clk);
    trip = 1'b0;
    check("R10 off uses old sink", g, 4'b0001);
    run_phase(2'b11, n);
    check("R10 off length", n, 6);
    check("R10 new polarity next period", g, 4'b0100);
    @(negedge clk);
    check("R10 new pair", g, 4'b0110);
    go_idle();
  endtask

  task automatic t_enable();
    polarity = 1'b0; decay_mixed = 1'b1; off_cycles = 16'd30;
    trip = 1'b0; enable = 1'b1;
    repeat (8) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check("R11 disable in drive", {phase, g}, 0);
    trip = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 stays idle", {phase, g}, 0);
    trip = 1'b0;
    enable = 1'b1;
    @(negedge clk);
    check("R11 restart sink-first", {phase, g}, {2'b01, 4'b0001});
    repeat (8) @(negedge clk);
    trip = 1'b1;
    @(negedge clk);
    check("R11 in fast decay", phase, 2);
    enable = 1'b0;
    @(negedge clk);
    check("R11 disable in decay", {phase, g}, 0);
    go_idle();
  endtask

  task automatic t_reset_mid();
    polarity = 1'b1; decay_mixed = 1'b0; off_cycles = 16'd10;
    trip = 1'b0; enable = 1'b1;
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async clear", {phase, g}, 0);
    enable = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle after second release", {phase, g}, 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_slow();
    t_trip_edge();
    t_mixed();
    t_lowcur();
    t_minoff();
    t_polarity();
    t_enable();
    t_reset_mid();
    check("R9 overlap/break-before-make violations", viol, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule